// File: doc/BRIEF.md
# Instruction Fetch Translation Checker

This block sits beside the instruction TLB and decides, for every fetch address, what the fetch unit gets back: a bypassed physical address, a translated physical address, or a trap code with the side values a trap handler needs. It decodes a 64-bit MMU control word. That decode yields the privilege and trap-level state and picks the lookup key it presents to the TLB: address, partition, context and a real/virtual flag. It then applies the checks in a fixed priority.

Requests arrive on a valid/ready stream together with the control word, the fetch address and the valid bit of the current fault status register. The TLB answers combinationally in the same cycle on the lookup pins. The result leaves one cycle later on a valid/ready response stream through a single output register. A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` is high whenever the output register is empty or is being drained in the same cycle, so a stalled consumer stalls the producer at once. A response that is not taken stays in place, unchanged, until `rsp_ready` is high.

Top module: `ifc_xlate_check`

## Requirements
- R1: `req_ready` equals `!rsp_valid || rsp_ready`. An accepted request appears on the response port in the next cycle. A response held while `rsp_ready` is low keeps all its fields unchanged.
- R2: Control word fields: bit 0 hyper-privileged, bit 1 red state, bit 2 privileged, bit 3 address mask, bit 4 instruction MMU enable, bits 15:8 partition, bits 18:16 trap level, bits 47:32 primary context. `lk_part` carries the partition.
- R3: If bit 0 or bit 1 is set, the fetch is bypassed. Then `rsp_bypass`=1, trap code 0, `rsp_real`=0, and `rsp_paddr` is the fetch address with bits 63:40 cleared. Tag and status outputs are 0.
- R4: If the address is not bypassed and its bits 1:0 are nonzero, the trap code is 1 (alignment).
- R5: The virtual hole is the range 0x0000_8000_0000_0000 to 0xFFFF_7FFF_FFFF_FFFF, inclusive. With the address mask clear, an address in the hole gives trap code 2 (range). With the mask set, the address is cut to its low 32 bits, both for the lookup and for the result, and no hole check is made.
- R6: Lookup key. With the MMU enable clear, the lookup is real (`lk_real`=1) with context 0. Otherwise it is virtual, with context 0 when the trap level is nonzero and the primary context when it is zero. `rsp_real` repeats the real flag for every non-bypassed result.
- R7: On a miss, `rsp_tag` is the lookup address with bits 12:0 cleared, ORed with the lookup context. The trap code is 3 for a real miss and 4 for a virtual miss.
- R8: A hit on a privileged page while the privileged bit is clear gives trap code 5.
- R9: On a clean hit, `rsp_paddr` = (`lk_pa` with its low `lk_pgsh` bits cleared) OR (lookup address masked to its low `lk_pgsh` bits). Trap code 0.
- R10: Fault status for trap codes 1, 2 and 5 is built as follows. Bits 1:0 are 3 if `req_fsr_vld` is set, else 1. Bits 2 and 6 are 0 (fetch is neither write nor side-effect). Bits 5:4 hold the context type: 2 if the trap level is nonzero, else 0. Bits 15:7 hold the fault type: 0x008 alignment, 0x002 range, 0x001 privilege. Bits 23:16 hold the address space: 0x04 if the trap level is nonzero, else 0x80. For all other codes `rsp_fsr` is 0.
- R11: Checks apply in this order: bypass, alignment, range, miss, privilege. A fetch that is both misaligned and in the hole reports alignment.
- R12: After reset `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle |
| req_ctl | input | 64 | MMU control word |
| req_va | input | 64 | Fetch virtual address |
| req_fsr_vld | input | 1 | Valid bit of the current fault status register |
| lk_va | output | 64 | Lookup address (after address mask) |
| lk_part | output | 8 | Lookup partition |
| lk_ctx | output | 16 | Lookup context |
| lk_real | output | 1 | Lookup is real |
| lk_hit | input | 1 | TLB hit |
| lk_priv | input | 1 | Hit page is privileged |
| lk_pa | input | 64 | Physical page address of the hit entry |
| lk_pgsh | input | 6 | Page-offset width of the hit entry |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_trap | output | 3 | Trap code (0 none) |
| rsp_bypass | output | 1 | Translation bypassed |
| rsp_real | output | 1 | Lookup was real |
| rsp_paddr | output | 64 | Physical address |
| rsp_tag | output | 64 | Tag-access value on a miss |
| rsp_fsr | output | 64 | Updated fault status on a fault |

## Verification
The hardest situation to reach is a response stalled in the output register while a new request waits, because both stream sides must line up in the same cycle. The bench lowers `rsp_ready` at random during a long burst of back-to-back requests. While a response is held, it checks that the response stays unchanged and that no request slips through. The other hard cases are the overlapping checks: a misaligned address inside the hole, a bypass on a misaligned address, and a hole address with the mask set that then goes on to hit. The bench steers to each of these with directed vectors before the random burst.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
  typedef enum logic [2:0] {
    TRAP_NONE      = 3'd0,
    TRAP_ALIGN     = 3'd1,
    TRAP_RANGE     = 3'd2,
    TRAP_MISS_REAL = 3'd3,
    TRAP_MISS_VIRT = 3'd4,
    TRAP_PRIV      = 3'd5
  } trap_e;

  localparam int CTL_W   = 64;
  localparam int B_HPRIV = 0;
  localparam int B_RED   = 1;
  localparam int B_PRIV  = 2;
  localparam int B_AMASK = 3;
  localparam int B_IMMU  = 4;
  localparam int PART_LO = 8;
  localparam int PART_HI = 15;
  localparam int TL_LO   = 16;
  localparam int TL_HI   = 18;
  localparam int PCTX_LO = 32;
  localparam int PCTX_HI = 47;
  localparam int PART_W  = PART_HI - PART_LO + 1;
  localparam int TL_W    = TL_HI - TL_LO + 1;
  localparam int CTX_W   = PCTX_HI - PCTX_LO + 1;

  localparam logic [1:0] CT_PRIMARY = 2'd0;
  localparam logic [1:0] CT_NUCLEUS = 2'd2;
  localparam logic [7:0] AS_PRIMARY = 8'h80;
  localparam logic [7:0] AS_NUCLEUS = 8'h04;

  localparam int FT_W = 9;
  localparam logic [FT_W-1:0] FT_PRIV  = 9'h001;
  localparam logic [FT_W-1:0] FT_RANGE = 9'h002;
  localparam logic [FT_W-1:0] FT_OTHER = 9'h008;
endpackage

// File: rtl/ifc_ctl_decode.sv
module ifc_ctl_decode
  import ifc_pkg::*;
(
  input  logic [CTL_W-1:0]  ctl,
  output logic              bypass,
  output logic              priv,
  output logic              amask,
  output logic              real_lk,
  output logic [PART_W-1:0] part,
  output logic [CTX_W-1:0]  ctx,
  output logic [1:0]        ctx_type,
  output logic [7:0]        asi
);
  logic            nucleus;
  logic [TL_W-1:0] tl;
  logic            unused_ctl;

  assign unused_ctl = ^{ctl[CTL_W-1:PCTX_HI+1], ctl[PCTX_LO-1:TL_HI+1],
                        ctl[PART_LO-1:B_IMMU+1]};

  assign tl       = ctl[TL_HI:TL_LO];
  assign nucleus  = (tl != '0);
  assign bypass   = ctl[B_HPRIV] | ctl[B_RED];
  assign priv     = ctl[B_PRIV];
  assign amask    = ctl[B_AMASK];
  assign real_lk  = ~ctl[B_IMMU];
  assign part     = ctl[PART_HI:PART_LO];
  assign ctx_type = nucleus ? CT_NUCLEUS : CT_PRIMARY;
  assign asi      = nucleus ? AS_NUCLEUS : AS_PRIMARY;

  always_comb begin
    if (nucleus || real_lk) ctx = '0;
    else                    ctx = ctl[PCTX_HI:PCTX_LO];
  end
endmodule

// File: rtl/ifc_addr_check.sv
module ifc_addr_check #(
  parameter int             VA_W    = 64,
  parameter int             AM_BITS = 32,
  parameter logic [VA_W-1:0] HOLE_LO = 64'h0000_8000_0000_0000,
  parameter logic [VA_W-1:0] HOLE_HI = 64'hFFFF_7FFF_FFFF_FFFF
) (
  input  logic [VA_W-1:0] va,
  input  logic            amask,
  output logic [VA_W-1:0] va_eff,
  output logic            misalign,
  output logic            out_of_range
);
  localparam int HI_W = VA_W - AM_BITS;

  assign va_eff       = amask ? {{HI_W{1'b0}}, va[AM_BITS-1:0]} : va;
  assign misalign     = (va[1:0] != 2'b00);
  assign out_of_range = ~amask && (va >= HOLE_LO) && (va <= HOLE_HI);
endmodule

// File: rtl/ifc_fsr_build.sv
module ifc_fsr_build
  import ifc_pkg::*;
#(
  parameter int FSR_W = 64
) (
  input  logic            prev_vld,
  input  logic            wr,
  input  logic            side_eff,
  input  logic [1:0]      ctx_type,
  input  logic [FT_W-1:0] ftype,
  input  logic [7:0]      asi,
  output logic [FSR_W-1:0] fsr
);
  localparam int FT_LO  = 7;
  localparam int ASI_LO = 16;

  always_comb begin
    fsr                      = '0;
    fsr[1:0]                 = prev_vld ? 2'b11 : 2'b01;
    fsr[2]                   = wr;
    fsr[5:4]                 = ctx_type;
    fsr[6]                   = side_eff;
    fsr[FT_LO +: FT_W]       = ftype;
    fsr[ASI_LO +: 8]         = asi;
  end
endmodule

// File: rtl/ifc_xlate_check.sv
module ifc_xlate_check
  import ifc_pkg::*;
#(
  parameter int              VA_W    = 64,
  parameter int              PA_BITS = 40,
  parameter int              AM_BITS = 32,
  parameter int              PG_BITS = 13,
  parameter int              SH_W    = 6,
  parameter logic [VA_W-1:0] HOLE_LO = 64'h0000_8000_0000_0000,
  parameter logic [VA_W-1:0] HOLE_HI = 64'hFFFF_7FFF_FFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CTL_W-1:0]  req_ctl,
  input  logic [VA_W-1:0]   req_va,
  input  logic              req_fsr_vld,
  output logic [VA_W-1:0]   lk_va,
  output logic [PART_W-1:0] lk_part,
  output logic [CTX_W-1:0]  lk_ctx,
  output logic              lk_real,
  input  logic              lk_hit,
  input  logic              lk_priv,
  input  logic [VA_W-1:0]   lk_pa,
  input  logic [SH_W-1:0]   lk_pgsh,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [2:0]        rsp_trap,
  output logic              rsp_bypass,
  output logic              rsp_real,
  output logic [VA_W-1:0]   rsp_paddr,
  output logic [VA_W-1:0]   rsp_tag,
  output logic [63:0]       rsp_fsr
);
  localparam logic [VA_W-1:0] PA_MASK = (VA_W'(1) << PA_BITS) - VA_W'(1);

  logic            bypass, priv, amask, real_lk;
  logic [1:0]      ctx_type;
  logic [7:0]      asi;
  logic [VA_W-1:0] va_eff;
  logic            misalign, out_of_range;
  logic [FT_W-1:0] ftype;
  logic [63:0]     fsr_word;
  logic [VA_W-1:0] pg_mask, hit_pa, miss_tag;
  logic            accept;

  trap_e           n_trap;
  logic [VA_W-1:0] n_paddr, n_tag;
  logic [63:0]     n_fsr;
  logic            n_real;

  ifc_ctl_decode u_dec (
    .ctl      (req_ctl),
    .bypass   (bypass),
    .priv     (priv),
    .amask    (amask),
    .real_lk  (real_lk),
    .part     (lk_part),
    .ctx      (lk_ctx),
    .ctx_type (ctx_type),
    .asi      (asi)
  );

  ifc_addr_check #(
    .VA_W    (VA_W),
    .AM_BITS (AM_BITS),
    .HOLE_LO (HOLE_LO),
    .HOLE_HI (HOLE_HI)
  ) u_addr (
    .va           (req_va),
    .amask        (amask),
    .va_eff       (va_eff),
    .misalign     (misalign),
    .out_of_range (out_of_range)
  );

  ifc_fsr_build u_fsr (
    .prev_vld (req_fsr_vld),
    .wr       (1'b0),
    .side_eff (1'b0),
    .ctx_type (ctx_type),
    .ftype    (ftype),
    .asi      (asi),
    .fsr      (fsr_word)
  );

  assign lk_va   = va_eff;
  assign lk_real = real_lk;

  // Page composition for a hit and tag value for a miss.
  assign pg_mask  = (VA_W'(1) << lk_pgsh) - VA_W'(1);
  assign hit_pa   = (lk_pa & ~pg_mask) | (va_eff & pg_mask);
  assign miss_tag = {va_eff[VA_W-1:PG_BITS], {PG_BITS{1'b0}}} | VA_W'(lk_ctx);

  // Ordered checks: bypass, alignment, range, miss, privilege.
  always_comb begin
    n_trap  = TRAP_NONE;
    n_paddr = '0;
    n_tag   = '0;
    n_fsr   = '0;
    n_real  = ~bypass & real_lk;
    ftype   = FT_OTHER;
    if (bypass) begin
      n_paddr = req_va & PA_MASK;
    end else if (misalign) begin
      n_trap = TRAP_ALIGN;
      ftype  = FT_OTHER;
      n_fsr  = fsr_word;
    end else if (out_of_range) begin
      n_trap = TRAP_RANGE;
      ftype  = FT_RANGE;
      n_fsr  = fsr_word;
    end else if (!lk_hit) begin
      n_trap = real_lk ? TRAP_MISS_REAL : TRAP_MISS_VIRT;
      n_tag  = miss_tag;
    end else if (!priv && lk_priv) begin
      n_trap = TRAP_PRIV;
      ftype  = FT_PRIV;
      n_fsr  = fsr_word;
    end else begin
      n_paddr = hit_pa;
    end
  end

  assign req_ready = ~rsp_valid | rsp_ready;
  assign accept    = req_valid & req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_trap   <= TRAP_NONE;
      rsp_bypass <= 1'b0;
      rsp_real   <= 1'b0;
      rsp_paddr  <= '0;
      rsp_tag    <= '0;
      rsp_fsr    <= '0;
    end else if (req_ready) begin
      rsp_valid <= req_valid;
      if (accept) begin
        rsp_trap   <= n_trap;
        rsp_bypass <= bypass;
        rsp_real   <= n_real;
        rsp_paddr  <= n_paddr;
        rsp_tag    <= n_tag;
        rsp_fsr    <= n_fsr;
      end
    end
  end
endmodule

// File: rtl/ifc_xlate_check_sva.sv
module ifc_xlate_check_sva #(
  parameter int VA_W    = 64,
  parameter int PA_BITS = 40,
  parameter int PG_BITS = 13
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [2:0]      rsp_trap,
  input logic            rsp_bypass,
  input logic            rsp_real,
  input logic [VA_W-1:0] rsp_paddr,
  input logic [VA_W-1:0] rsp_tag,
  input logic [63:0]     rsp_fsr
);
  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_trap) && $stable(rsp_paddr)
      && $stable(rsp_tag) && $stable(rsp_fsr) && $stable(rsp_bypass) && $stable(rsp_real));

  p_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_bypass |-> rsp_trap == 3'd0 && !rsp_real
      && (rsp_paddr >> PA_BITS) == '0);

  p_realmiss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_trap == 3'd3 |-> rsp_real && rsp_tag[PG_BITS-1:0] == '0);

  p_fault_fsr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_trap == 3'd1 || rsp_trap == 3'd2 || rsp_trap == 3'd5)
      |-> rsp_fsr[0] && !rsp_fsr[2] && !rsp_fsr[6]);

  p_quiet_fsr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_trap == 3'd0 || rsp_trap == 3'd3 || rsp_trap == 3'd4)
      |-> rsp_fsr == '0);

  p_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_trap <= 3'd5);
endmodule

bind ifc_xlate_check ifc_xlate_check_sva #(
  .VA_W    (VA_W),
  .PA_BITS (PA_BITS),
  .PG_BITS (PG_BITS)
) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_trap   (rsp_trap),
  .rsp_bypass (rsp_bypass),
  .rsp_real   (rsp_real),
  .rsp_paddr  (rsp_paddr),
  .rsp_tag    (rsp_tag),
  .rsp_fsr    (rsp_fsr)
);

// File: tb/ifc_xlate_check_test.sv
module ifc_xlate_check_test;
  typedef struct packed {
    logic [63:0] ctl;
    logic [63:0] va;
    logic        fsrv;
    logic        hit;
    logic        priv;
    logic [63:0] pa;
    logic [5:0]  sh;
  } stim_t;

  typedef struct packed {
    logic [2:0]  trap;
    logic        bypass;
    logic        rl;
    logic [63:0] paddr;
    logic [63:0] tag;
    logic [63:0] fsr;
    logic [63:0] lkva;
    logic [15:0] lkctx;
    logic [7:0]  lkpart;
    logic        lkreal;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [63:0] req_ctl = '0;
  logic [63:0] req_va = '0;
  logic req_fsr_vld = 1'b0;
  logic [63:0] lk_va;
  logic [7:0]  lk_part;
  logic [15:0] lk_ctx;
  logic lk_real;
  logic lk_hit = 1'b0;
  logic lk_priv = 1'b0;
  logic [63:0] lk_pa = '0;
  logic [5:0]  lk_pgsh = 6'd13;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic [2:0] rsp_trap;
  logic rsp_bypass, rsp_real;
  logic [63:0] rsp_paddr, rsp_tag, rsp_fsr;

  int checks = 0;
  int fails = 0;
  bit stall_mode = 1'b0;
  bit done = 1'b0;
  exp_t sb[$];

  always #5 clk = ~clk;

  ifc_xlate_check uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_ctl(req_ctl), .req_va(req_va), .req_fsr_vld(req_fsr_vld),
    .lk_va(lk_va), .lk_part(lk_part), .lk_ctx(lk_ctx), .lk_real(lk_real),
    .lk_hit(lk_hit), .lk_priv(lk_priv), .lk_pa(lk_pa), .lk_pgsh(lk_pgsh),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_trap(rsp_trap),
    .rsp_bypass(rsp_bypass), .rsp_real(rsp_real), .rsp_paddr(rsp_paddr),
    .rsp_tag(rsp_tag), .rsp_fsr(rsp_fsr)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Expected result written from the requirements.
  function automatic exp_t model(stim_t s);
    exp_t e;
    logic nuc, im, am;
    logic [63:0] veff, f, m;
    e   = '0;
    nuc = (s.ctl[18:16] != 3'd0);
    im  = s.ctl[4];
    am  = s.ctl[3];
    veff = am ? {32'h0, s.va[31:0]} : s.va;
    e.lkva   = veff;
    e.lkpart = s.ctl[15:8];
    e.lkreal = !im;
    e.lkctx  = (nuc || !im) ? 16'h0 : s.ctl[47:32];
    f = (s.fsrv ? 64'd3 : 64'd1) | (64'(nuc ? 2 : 0) << 4)
        | (64'(nuc ? 8'h04 : 8'h80) << 16);
    if (s.ctl[0] || s.ctl[1]) begin                      // R3
      e.bypass = 1'b1;
      e.paddr  = s.va & 64'h0000_00FF_FFFF_FFFF;
      return e;
    end
    e.rl = !im;
    if (s.va[1:0] != 2'b00) begin                        // R4
      e.trap = 3'd1; e.fsr = f | (64'h008 << 7);
    end else if (!am && s.va >= 64'h0000_8000_0000_0000
                 && s.va <= 64'hFFFF_7FFF_FFFF_FFFF) begin // R5
      e.trap = 3'd2; e.fsr = f | (64'h002 << 7);
    end else if (!s.hit) begin                           // R7
      e.trap = im ? 3'd4 : 3'd3;
      e.tag  = {veff[63:13], 13'h0} | 64'(e.lkctx);
    end else if (!s.ctl[2] && s.priv) begin              // R8
      e.trap = 3'd5; e.fsr = f | (64'h001 << 7);
    end else begin                                       // R9
      m = (64'd1 << s.sh) - 64'd1;
      e.paddr = (s.pa & ~m) | (veff & m);
    end
    return e;
  endfunction

  task automatic send(input stim_t s);
    exp_t e;
    e = model(s);
    @(negedge clk);
    req_valid   = 1'b1;
    req_ctl     = s.ctl;
    req_va      = s.va;
    req_fsr_vld = s.fsrv;
    lk_hit      = s.hit;
    lk_priv     = s.priv;
    lk_pa       = s.pa;
    lk_pgsh     = s.sh;
    forever begin
      #4;
      if (req_ready) begin
        checks++;                                        // R2 R5 R6 lookup key
        chk("R2 lk_part", 64'(lk_part), 64'(e.lkpart));
        chk("R6 lk_ctx", 64'(lk_ctx), 64'(e.lkctx));
        chk("R6 lk_real", 64'(lk_real), 64'(e.lkreal));
        chk("R5 lk_va", lk_va, e.lkva);
        sb.push_back(e);
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic stim_t mk(input logic [63:0] ctl, input logic [63:0] va,
                               input logic fsrv, input logic hit, input logic priv,
                               input logic [63:0] pa, input logic [5:0] sh);
    stim_t s;
    s.ctl = ctl; s.va = va; s.fsrv = fsrv; s.hit = hit; s.priv = priv;
    s.pa = pa; s.sh = sh;
    return s;
  endfunction

  // Monitor: pops the scoreboard when a response is taken, checks holds.
  initial begin
    bit held;
    logic [2:0]  h_trap;
    logic [63:0] h_pa, h_tag, h_fsr;
    exp_t e;
    held = 1'b0;
    h_trap = '0; h_pa = '0; h_tag = '0; h_fsr = '0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      rsp_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
      #4;
      if (held && rsp_valid) begin                       // R1 hold while stalled
        checks++;
        chk("R1 hold trap", 64'(rsp_trap), 64'(h_trap));
        chk("R1 hold paddr", rsp_paddr, h_pa);
        chk("R1 hold tag", rsp_tag, h_tag);
        chk("R1 hold fsr", rsp_fsr, h_fsr);
        chk("R1 ready low", 64'(req_ready), 64'(rsp_ready));
      end
      held = 1'b0;
      if (rsp_valid && !rsp_ready) begin
        held = 1'b1;
        h_trap = rsp_trap; h_pa = rsp_paddr; h_tag = rsp_tag; h_fsr = rsp_fsr;
      end else if (rsp_valid) begin
        checks++;
        if (sb.size() == 0) begin
          fails++;
          $display("FAIL R1: unexpected response got %h expected none", rsp_paddr);
        end else begin
          e = sb.pop_front();
          chk("R11 trap", 64'(rsp_trap), 64'(e.trap));
          chk("R3 bypass", 64'(rsp_bypass), 64'(e.bypass));
          chk("R6 real", 64'(rsp_real), 64'(e.rl));
          chk("R9 paddr", rsp_paddr, e.paddr);
          chk("R7 tag", rsp_tag, e.tag);
          chk("R10 fsr", rsp_fsr, e.fsr);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] c;
    repeat (3) @(posedge clk);
    #1;
    checks++;                                            // R12 reset state
    chk("R12 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R12 req_ready", 64'(req_ready), 64'd1);
    @(negedge clk);
    rst_n = 1'b1;

    // ctl: part 0x5A, primary ctx 0x1234, MMU on, privileged clear
    c = 64'h0000_1234_0000_5A10;
    send(mk(c | 64'h1, 64'hFFFF_FFAB_CDEF_0123, 0, 0, 0, 0, 13)); // R3 hpriv bypass
    send(mk(c | 64'h2, 64'h0000_0012_3456_7001, 0, 0, 0, 0, 13)); // R3 red bypass beats R4
    send(mk(c, 64'h0000_0000_0040_0002, 0, 1, 0, 0, 13));         // R4 align tl=0
    send(mk(c | 64'h2_0000, 64'h0000_0000_0040_0001, 1, 1, 0, 0, 13)); // R4 R10 tl=2 sticky
    send(mk(c, 64'h0000_9000_0000_0000, 0, 0, 0, 0, 13));         // R5 hole
    send(mk(c, 64'h0000_9000_0000_0003, 0, 0, 0, 0, 13));         // R11 align over range
    send(mk(c | 64'h8, 64'h0000_9000_0000_4004, 0, 1, 0,
            64'h0000_0055_5550_0000, 13));                         // R5 masked, hits
    send(mk(c & ~64'h10, 64'h0000_0000_1234_5678, 0, 0, 0, 0, 13)); // R6 R7 real miss
    send(mk(c, 64'h0000_0000_1234_5678, 0, 0, 0, 0, 13));         // R7 virtual miss
    send(mk(c | 64'h3_0000, 64'h0000_0000_1234_5678, 0, 0, 0, 0, 13)); // R6 tl>0 ctx 0
    send(mk(c, 64'h0000_0000_0000_2000, 0, 1, 1, 64'h0000_0001_0000_0000, 13)); // R8
    send(mk(c | 64'h4, 64'h0000_0000_0000_2468, 0, 1, 1,
            64'h0000_0001_0000_0000, 13));                         // R8 priv ok, R9
    send(mk(c, 64'h0000_0000_00AB_CDE4, 0, 1, 0,
            64'h0000_00FF_FFFF_FFFF, 22));                         // R9 large page
    send(mk(c, 64'hFFFF_8000_0000_0000, 0, 0, 0, 0, 13));         // R5 just above hole

    // R1: back-to-back burst with random back-pressure.
    stall_mode = 1'b1;
    for (int i = 0; i < 60; i++) begin
      stim_t s;
      s.ctl  = {$urandom, $urandom} & 64'h0000_FFFF_0007_FF1F;
      if (($urandom % 4) != 0) s.ctl[1:0] = 2'b00;
      s.va   = {$urandom, $urandom};
      if (($urandom % 2) != 0) s.va[63:47] = '0;
      if (($urandom % 3) != 0) s.va[1:0] = 2'b00;
      s.fsrv = 1'($urandom);
      s.hit  = 1'($urandom);
      s.priv = 1'($urandom);
      s.pa   = {$urandom, $urandom};
      s.sh   = 6'(13 + ($urandom % 16));
      fork
        send(s);
      join
    end
    stall_mode = 1'b0;
    repeat (10) @(posedge clk);
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R1: got %0d pending expected 0", sb.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule